// File: doc/BRIEF.md
# Memory Access Wait-State Generator

This block holds off the bus acknowledge of an external-memory access for a number of cycles that depends on the kind of memory behind the selected chip select. The memory type and the 32-bit timing word of that chip select are presented together with the access direction. The block adds the relevant packed timing fields to form a wait count. A one-cycle start strobe then launches a countdown.

While the countdown runs, `busy_o` is high. When it expires, `done_o` pulses for exactly one cycle, and the bus side can acknowledge the access. A start strobe that arrives while the block is busy is dropped. The surrounding controller therefore issues a new start only after it has seen `done_o`.

Top module: `mem_wait_gen`

## Requirements
- R1: After reset is released, `busy_o` and `done_o` are both 0 until a start strobe is accepted.
- R2: With memory type code 2 (asynchronous) and a read (`write_i`=0), the latency L is timing[7:0] + timing[11:8].
- R3: With memory type code 2 and a write (`write_i`=1), L is timing[15:12] + timing[19:16] + timing[25:20]. The sum is formed 10 bits wide, so the largest value, 93, is exact.
- R4: With memory type code 0 (SDRAM), L is 3 + timing[5:4] for both reads and writes.
- R5: With memory type code 1 (synchronous burst SRAM), code 3 (other synchronous device) and any code from 4 to 7, L is 2 for both directions. Timing bits are then ignored.
- R6: The block accepts a start strobe that is high in cycle c while the block is idle. `busy_o` is then high in cycles c+1 through c+1+L, and `done_o` is high only in cycle c+1+L. In cycle c+2+L the block is idle again.
- R7: When L is 0, `done_o` is high in the cycle right after the start cycle, and `busy_o` is high in that cycle only.
- R8: A start strobe while `busy_o` is high has no effect. The running access completes at its original time, and no extra `done_o` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for one access |
| write_i | input | 1 | Access direction: 1 for write, 0 for read |
| mem_type_i | input | 3 | Memory type code of the selected chip select |
| timing_i | input | 32 | Timing word of the selected chip select |
| busy_o | output | 1 | Access is being held off |
| done_o | output | 1 | One-cycle pulse when the wait has elapsed |

## Verification
The asynchronous type is tried in both directions with timing words that load different fields. This shows that the read sum and the write sum each take only their own bit ranges, and the all-ones write field confirms the 10-bit sum does not wrap. SDRAM is tried with both values of its field and with noise in the other timing bits, which separates the field from the constant offset. The fixed-latency types, including the unused codes, are given busy timing words so that any use of a field would show. A zero-latency access and a start strobe injected in the middle of a countdown test the edge cases of the state machine.

// File: rtl/mwg_pkg.sv
package mwg_pkg;

  typedef enum logic [2:0] {
    MT_SDRAM = 3'd0,
    MT_SSRAM = 3'd1,
    MT_ASYNC = 3'd2,
    MT_SYNC  = 3'd3
  } mem_type_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_DONE  = 2'd2
  } wait_state_e;

  localparam int unsigned FIXED_LAT  = 2;
  localparam int unsigned SDRAM_BASE = 3;

  // timing word field positions
  localparam int unsigned RD_A_LSB = 0,  RD_A_W = 8;
  localparam int unsigned RD_B_LSB = 8,  RD_B_W = 4;
  localparam int unsigned WR_A_LSB = 12, WR_A_W = 4;
  localparam int unsigned WR_B_LSB = 16, WR_B_W = 4;
  localparam int unsigned WR_C_LSB = 20, WR_C_W = 6;
  localparam int unsigned SD_LSB   = 4,  SD_W   = 2;

endpackage

// File: rtl/mwg_latency_calc.sv
module mwg_latency_calc
  import mwg_pkg::*;
#(
  parameter int unsigned TIM_W = 32,
  parameter int unsigned LAT_W = 10
) (
  input  logic [2:0]       mem_type_i,
  input  logic             write_i,
  input  logic [TIM_W-1:0] timing_i,
  output logic [LAT_W-1:0] lat_o
);

  logic [LAT_W-1:0] rd_async, wr_async, sdram_lat;

  always_comb begin
    rd_async  = LAT_W'(timing_i[RD_A_LSB +: RD_A_W])
              + LAT_W'(timing_i[RD_B_LSB +: RD_B_W]);
    wr_async  = LAT_W'(timing_i[WR_A_LSB +: WR_A_W])
              + LAT_W'(timing_i[WR_B_LSB +: WR_B_W])
              + LAT_W'(timing_i[WR_C_LSB +: WR_C_W]);
    sdram_lat = LAT_W'(SDRAM_BASE) + LAT_W'(timing_i[SD_LSB +: SD_W]);
  end

  always_comb begin
    case (mem_type_e'(mem_type_i))
      MT_ASYNC: lat_o = write_i ? wr_async : rd_async;
      MT_SDRAM: lat_o = sdram_lat;
      default:  lat_o = LAT_W'(FIXED_LAT);
    endcase
  end

  // R3: the sum must cover each field it adds
  always_comb begin
    if (mem_type_i == MT_ASYNC && write_i)
      assert_no_overflow_R3: assert (lat_o >= LAT_W'(timing_i[WR_C_LSB +: WR_C_W]));
  end

endmodule

// File: rtl/mwg_countdown.sv
module mwg_countdown
  import mwg_pkg::*;
#(
  parameter int unsigned LAT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic             busy_o,
  output logic             done_o
);

  localparam logic [LAT_W-1:0] CNT_ONE = LAT_W'(1);

  wait_state_e      state_q;
  logic [LAT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          cnt_q   <= lat_i;
          state_q <= (lat_i == '0) ? ST_DONE : ST_COUNT;
        end
        ST_COUNT: begin
          cnt_q <= cnt_q - CNT_ONE;
          if (cnt_q == CNT_ONE) state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_DONE);

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_count_progress_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COUNT && cnt_q > CNT_ONE) |=>
      (state_q == ST_COUNT && cnt_q == $past(cnt_q) - CNT_ONE));

  assert_zero_lat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && lat_i == '0) |=> done_o);

  assert_ignore_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i) |=> !busy_o);

endmodule

// File: rtl/mem_wait_gen.sv
module mem_wait_gen
  import mwg_pkg::*;
#(
  parameter int unsigned TIM_W = 32,
  parameter int unsigned LAT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             write_i,
  input  logic [2:0]       mem_type_i,
  input  logic [TIM_W-1:0] timing_i,
  output logic             busy_o,
  output logic             done_o
);

  logic [LAT_W-1:0] lat;

  mwg_latency_calc #(.TIM_W(TIM_W), .LAT_W(LAT_W)) u_calc (
    .mem_type_i (mem_type_i),
    .write_i    (write_i),
    .timing_i   (timing_i),
    .lat_o      (lat)
  );

  mwg_countdown #(.LAT_W(LAT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .lat_i   (lat),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  assert_busy_origin_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> !busy_o);

endmodule

// File: tb/mem_wait_gen_tb.sv
module mem_wait_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        wr = 1'b0;
  logic [2:0]  mtype = 3'd0;
  logic [31:0] timing = 32'd0;
  logic        busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  mem_wait_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .write_i(wr),
    .mem_type_i(mtype), .timing_i(timing), .busy_o(busy), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // issue one access; optionally inject a second start at cycle inj (0 = none)
  task automatic run_access(input string req, input logic [2:0] t, input bit w,
                            input logic [31:0] tw, input int exp_lat, input int inj);
    int n, done_at, busy_cnt, done_cnt;
    @(negedge clk);
    mtype = t; wr = w; timing = tw; start = 1'b1;
    done_at = -1; busy_cnt = 0; done_cnt = 0;
    for (n = 1; n <= exp_lat + 8; n++) begin
      @(negedge clk);
      start = (inj != 0 && n == inj);
      if (start) begin mtype = 3'd1; timing = 32'd0; end
      if (busy) busy_cnt++;
      if (done) begin done_cnt++; if (done_at < 0) done_at = n; end
    end
    start = 1'b0;
    check(done_at == exp_lat + 1, req, done_at, exp_lat + 1);
    check(done_cnt == 1, {req, " R6 done pulse count"}, done_cnt, 1);
    check(busy_cnt == exp_lat + 1, {req, " R6 busy cycles"}, busy_cnt, exp_lat + 1);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    check(done == 1'b0, "R1 done after reset", done, 0);
  endtask

  task automatic test_async();
    run_access("R2 async read", 3'd2, 1'b0, 32'hFFFF_F035, 'h35 + 0, 0);
    run_access("R2 async read both", 3'd2, 1'b0, 32'h0000_0A07, 7 + 10, 0);
    run_access("R3 async write", 3'd2, 1'b1, 32'h0035_4FFF, 3 + 5 + 4, 0);
    run_access("R3 async write max", 3'd2, 1'b1, 32'h03FF_F000, 93, 0);
  endtask

  task automatic test_sdram();
    run_access("R4 sdram read", 3'd0, 1'b0, 32'hFFFF_FFCF, 3, 0);
    run_access("R4 sdram write", 3'd0, 1'b1, 32'h0000_0030, 6, 0);
    run_access("R4 sdram mid", 3'd0, 1'b0, 32'h0000_0010, 4, 0);
  endtask

  task automatic test_fixed();
    run_access("R5 ssram", 3'd1, 1'b0, 32'hFFFF_FFFF, 2, 0);
    run_access("R5 sync write", 3'd3, 1'b1, 32'hFFFF_FFFF, 2, 0);
    run_access("R5 code 6", 3'd6, 1'b0, 32'h0000_0FFF, 2, 0);
  endtask

  task automatic test_zero();
    run_access("R7 zero latency", 3'd2, 1'b0, 32'hFFFF_F000, 0, 0);
  endtask

  task automatic test_ignore();
    run_access("R8 start mid count", 3'd2, 1'b0, 32'h0000_0005, 5, 3);
    run_access("R8 start on done", 3'd2, 1'b0, 32'h0000_0004, 4, 5);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_async();
    test_sdram();
    test_fixed();
    test_zero();
    test_ignore();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule